// File: doc/BRIEF.md
# Cell Threshold Alarm with Latched Status

This block watches three live measurements of a single battery cell: voltage in mV, temperature in 0.1 K steps (0x0AAC is 0 °C), and state of charge in percent. Each arrives as a one-cycle valid pulse with a 16-bit value. Each measurement is compared against threshold registers that software programs. When a value is outside its window, the block pulls an active-low alarm pin and sets a bit in a 16-bit status word. The pin follows the present condition. A status bit, once set, stays set until the host writes the status word.

The measurement inputs have no ready signal. Every valid pulse is accepted in the cycle it occurs, so the block never applies back-pressure. The upstream source needs no flow control. The block stores the last accepted value of each channel. The alarm pin is re-evaluated every cycle from those stored values and the current thresholds and enables. The voltage and temperature thresholds are meant for the range 0x09C4..0x1388 mV and 0x0980..0x0DCC (0.1 K) respectively. The comparisons are unsigned and accept any code.

Top module: `cell_alarm_monitor`

## Requirements
- R1: Status bit positions are: 15 voltage-high, 12 temperature-high, 11 voltage-low, 9 charge-low, 8 temperature-low, 7 init flag, 6 discharge flag. Bits 14, 13, 10 and 5..0 always read 0.
- R2: After reset the status word is 0x00C0 (bits 7 and 6 set) and `alarm_n` is 1.
- R3: When a valid sample is strictly below a non-zero low threshold, or strictly above a non-zero high threshold, the matching status bit reads 1 from the clock edge that captures the sample.
- R4: A threshold of 0x0000 disables its alarm. It sets no status bit and does not drive the pin.
- R5: When `therm_en` is 0, both temperature alarms are disabled, for the status bits and for the pin.
- R6: An alarm bit stays 1 after its condition clears, until the host writes the status word or a reset occurs.
- R7: A host write loads `st_wdata` into bits 15, 12, 11, 9, 8, 7 and 6. Writing 0 clears them.
- R8: If a host write and a sample that meets an enabled condition occur in the same cycle, the bit for that condition ends at 1.
- R9: `alarm_n` is 0 in the cycle after any enabled condition holds on the stored values, and it returns to 1 one cycle after none holds. A channel raises no pin alarm before its first sample.
- R10: A value equal to its threshold is not an alarm condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| volt_vld | input | 1 | Voltage sample valid pulse |
| volt_val | input | 16 | Cell voltage, mV |
| temp_vld | input | 1 | Temperature sample valid pulse |
| temp_val | input | 16 | Cell temperature, 0.1 K |
| soc_vld | input | 1 | Charge sample valid pulse |
| soc_val | input | 16 | State of charge, % |
| thr_volt_lo | input | 16 | Low voltage threshold, 0 disables |
| thr_volt_hi | input | 16 | High voltage threshold, 0 disables |
| thr_temp_lo | input | 16 | Low temperature threshold, 0 disables |
| thr_temp_hi | input | 16 | High temperature threshold, 0 disables |
| thr_soc_lo | input | 16 | Low charge threshold, 0 disables |
| therm_en | input | 1 | Thermistor measurement enable; 0 disables temperature alarms |
| st_wr | input | 1 | Host write strobe for status word |
| st_wdata | input | 16 | Host write data |
| status | output | 16 | Status word |
| alarm_n | output | 1 | Alarm pin, active low |

## Verification
Two functions can meet in one cycle: a host write that clears the latched bits, and a sample that raises the same bit. The bench provokes this by issuing a write of zero together with a charge sample below its threshold. It then expects the charge-low bit to read 1 on the following cycle, while every other alarm bit reads 0. In the same way, a write and an in-range voltage sample are issued together, to confirm that the write alone decides the result when no condition holds.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DW = 16;
  localparam int NCH = 3;
  localparam int CH_VOLT = 0;
  localparam int CH_TEMP = 1;
  localparam int CH_SOC  = 2;

  localparam int B_VHI  = 15;
  localparam int B_THI  = 12;
  localparam int B_VLO  = 11;
  localparam int B_SLO  = 9;
  localparam int B_TLO  = 8;
  localparam int B_INIT = 7;
  localparam int B_DSG  = 6;

  localparam logic [DW-1:0] ALARM_MASK =
    (DW'(1) << B_VHI) | (DW'(1) << B_THI) | (DW'(1) << B_VLO) |
    (DW'(1) << B_SLO) | (DW'(1) << B_TLO);
  localparam logic [DW-1:0] FLAG_MASK = (DW'(1) << B_INIT) | (DW'(1) << B_DSG);
  localparam logic [DW-1:0] WR_MASK   = ALARM_MASK | FLAG_MASK;
  localparam logic [DW-1:0] RST_VAL   = FLAG_MASK;

  typedef struct packed {
    logic lo;
    logic hi;
  } cond_t;
endpackage

// File: rtl/chan_track.sv
module chan_track
  import alarm_pkg::*;
#(
  parameter int W = DW,
  parameter bit HAS_HI = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld,
  input  logic [W-1:0] val,
  input  logic [W-1:0] thr_lo,
  input  logic [W-1:0] thr_hi,
  input  logic         gate,
  output cond_t        live,
  output cond_t        hit
);
  logic [W-1:0] held;
  logic         seen;

  function automatic cond_t judge(input logic [W-1:0] v, input logic [W-1:0] lo,
                                  input logic [W-1:0] hi, input logic g);
    cond_t c;
    c.lo = g && (lo != '0) && (v < lo);
    c.hi = HAS_HI && g && (hi != '0) && (v > hi);
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
      seen <= 1'b0;
    end else if (vld) begin
      held <= val;
      seen <= 1'b1;
    end
  end

  always_comb begin
    cond_t c;
    c = judge(held, thr_lo, thr_hi, gate);
    live.lo = seen && c.lo;
    live.hi = seen && c.hi;
    if (vld) hit = judge(val, thr_lo, thr_hi, gate);
    else     hit = '0;
  end
endmodule

// File: rtl/status_word.sv
module status_word
  import alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] word
);
  logic [DW-1:0] base;

  always_comb begin
    base = wr ? (wdata & WR_MASK) : word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= RST_VAL;
    else        word <= base | (set_vec & ALARM_MASK);
  end
endmodule

// File: rtl/pin_driver.sv
module pin_driver #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] active,
  output logic         pin_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_n <= 1'b1;
    else        pin_n <= ~(|active);
  end
endmodule

// File: rtl/cell_alarm_monitor.sv
module cell_alarm_monitor
  import alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          volt_vld,
  input  logic [DW-1:0] volt_val,
  input  logic          temp_vld,
  input  logic [DW-1:0] temp_val,
  input  logic          soc_vld,
  input  logic [DW-1:0] soc_val,
  input  logic [DW-1:0] thr_volt_lo,
  input  logic [DW-1:0] thr_volt_hi,
  input  logic [DW-1:0] thr_temp_lo,
  input  logic [DW-1:0] thr_temp_hi,
  input  logic [DW-1:0] thr_soc_lo,
  input  logic          therm_en,
  input  logic          st_wr,
  input  logic [DW-1:0] st_wdata,
  output logic [DW-1:0] status,
  output logic          alarm_n
);
  localparam int NCOND = 2 * NCH;

  logic [NCH-1:0]         ch_vld;
  logic [NCH-1:0][DW-1:0] ch_val;
  logic [NCH-1:0][DW-1:0] ch_lo;
  logic [NCH-1:0][DW-1:0] ch_hi;
  logic [NCH-1:0]         ch_gate;
  cond_t [NCH-1:0]        ch_live;
  cond_t [NCH-1:0]        ch_hit;
  logic [NCOND-1:0]       live_flat;
  logic [DW-1:0]          set_vec;

  assign ch_vld  = {soc_vld, temp_vld, volt_vld};
  assign ch_val  = {soc_val, temp_val, volt_val};
  assign ch_lo   = {thr_soc_lo, thr_temp_lo, thr_volt_lo};
  assign ch_hi   = {DW'(0), thr_temp_hi, thr_volt_hi};
  assign ch_gate = {1'b1, therm_en, 1'b1};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chan_track #(.W(DW), .HAS_HI(i != CH_SOC)) u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .vld   (ch_vld[i]),
      .val   (ch_val[i]),
      .thr_lo(ch_lo[i]),
      .thr_hi(ch_hi[i]),
      .gate  (ch_gate[i]),
      .live  (ch_live[i]),
      .hit   (ch_hit[i])
    );
    assign live_flat[2*i]   = ch_live[i].lo;
    assign live_flat[2*i+1] = ch_live[i].hi;
  end

  always_comb begin
    set_vec        = '0;
    set_vec[B_VLO] = ch_hit[CH_VOLT].lo;
    set_vec[B_VHI] = ch_hit[CH_VOLT].hi;
    set_vec[B_TLO] = ch_hit[CH_TEMP].lo;
    set_vec[B_THI] = ch_hit[CH_TEMP].hi;
    set_vec[B_SLO] = ch_hit[CH_SOC].lo;
  end

  status_word u_st (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .wr     (st_wr),
    .wdata  (st_wdata),
    .word   (status)
  );

  pin_driver #(.N(NCOND)) u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .active(live_flat),
    .pin_n (alarm_n)
  );
endmodule

// File: rtl/cell_alarm_checker.sv
module cell_alarm_checker
  import alarm_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          temp_vld,
  input logic          soc_vld,
  input logic [DW-1:0] soc_val,
  input logic [DW-1:0] thr_soc_lo,
  input logic          therm_en,
  input logic          st_wr,
  input logic [DW-1:0] st_wdata,
  input logic [DW-1:0] status
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~WR_MASK) == '0);

  a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> ((status & $past(status)) == $past(status)));

  a_r4_soc_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (soc_vld && thr_soc_lo == '0 && !st_wr) |=> (status[B_SLO] == $past(status[B_SLO])));

  a_r5_temp_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_vld && !therm_en && !st_wr) |=>
      (status[B_TLO] == $past(status[B_TLO]) && status[B_THI] == $past(status[B_THI])));

  a_r8_sample_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && soc_vld && thr_soc_lo != '0 && soc_val < thr_soc_lo) |=> status[B_SLO]);

  a_r7_flags_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> ((status & FLAG_MASK) == ($past(st_wdata) & FLAG_MASK)));
endmodule

bind cell_alarm_monitor cell_alarm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .temp_vld  (temp_vld),
  .soc_vld   (soc_vld),
  .soc_val   (soc_val),
  .thr_soc_lo(thr_soc_lo),
  .therm_en  (therm_en),
  .st_wr     (st_wr),
  .st_wdata  (st_wdata),
  .status    (status)
);

// File: tb/sim_cell_alarm_monitor.sv
module sim_cell_alarm_monitor;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic volt_vld = 0, temp_vld = 0, soc_vld = 0, st_wr = 0, therm_en = 1;
  logic [15:0] volt_val = 0, temp_val = 0, soc_val = 0, st_wdata = 0;
  logic [15:0] thr_volt_lo = 16'd3000, thr_volt_hi = 16'd4200;
  logic [15:0] thr_temp_lo = 16'h0AAC, thr_temp_hi = 16'h0C6E, thr_soc_lo = 16'd10;
  logic [15:0] status;
  logic        alarm_n;

  always #2 clk = ~clk;

  cell_alarm_monitor u0 (.*);

  typedef struct {
    int          cyc;
    logic [15:0] val;
    bit          is_pin;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations when their cycle comes up
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      logic [15:0] act;
      e = q.pop_front();
      act = e.is_pin ? {15'd0, alarm_n} : status;
      n_chk++;
      if (e.cyc != cyc || act !== e.val) begin
        n_fail++;
        $display("FAIL %s %s: actual %h expected %h", e.tag,
                 e.is_pin ? "alarm_n" : "status", act, e.val);
      end
    end
  end

  // driver: one step drives a pulse and queues the expected outputs
  task automatic step(input int ch, input logic [15:0] v, input bit wr,
                      input logic [15:0] wd, input logic [15:0] exp_st,
                      input bit exp_pin, input string tag);
    @(negedge clk);
    volt_vld = (ch == 0); temp_vld = (ch == 1); soc_vld = (ch == 2);
    if (ch == 0) volt_val = v;
    if (ch == 1) temp_val = v;
    if (ch == 2) soc_val = v;
    st_wr = wr; st_wdata = wd;
    q.push_back('{cyc + 1, exp_st, 1'b0, tag});
    q.push_back('{cyc + 2, {15'd0, exp_pin}, 1'b1, tag});
    @(negedge clk);
    volt_vld = 0; temp_vld = 0; soc_vld = 0; st_wr = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    q.push_back('{cyc, 16'h00C0, 1'b0, "R2 reset status"});
    q.push_back('{cyc, 16'h0001, 1'b1, "R2 reset pin"});
    // R9: idle channel, no pin alarm before first sample
    step(3, 0, 1, 16'h0000, 16'h0000, 1, "R7 write zero");
    step(0, 16'd3700, 0, 0, 16'h0000, 1, "R9 voltage in range");
    step(0, 16'd2900, 0, 0, 16'h0800, 0, "R3 R1 voltage low bit11");
    step(0, 16'd3700, 0, 0, 16'h0800, 1, "R6 R9 sticky low, pin released");
    step(0, 16'd3000, 0, 0, 16'h0800, 1, "R10 equal to low threshold");
    step(0, 16'd4200, 0, 0, 16'h0800, 1, "R10 equal to high threshold");
    step(0, 16'd4300, 0, 0, 16'h8800, 0, "R3 R1 voltage high bit15");
    step(0, 16'd3700, 1, 16'h0000, 16'h0000, 1, "R7 write clears with quiet sample");
    step(1, 16'h0A00, 0, 0, 16'h0100, 0, "R3 R1 temp low bit8");
    step(1, 16'h0BA6, 0, 0, 16'h0100, 1, "R6 temp low sticky");
    step(1, 16'h0D00, 0, 0, 16'h1100, 0, "R3 R1 temp high bit12");
    step(1, 16'h0BA6, 1, 16'h0000, 16'h0000, 1, "R7 clear temp bits");
    therm_en = 0;
    step(1, 16'h0900, 0, 0, 16'h0000, 1, "R5 temp gated off");
    step(1, 16'h0BA6, 0, 0, 16'h0000, 1, "R5 temp gated in range");
    therm_en = 1;
    step(2, 16'd5, 0, 0, 16'h0200, 0, "R3 R1 charge low bit9");
    step(2, 16'd5, 1, 16'h0000, 16'h0200, 0, "R8 write and sample same cycle");
    thr_soc_lo = 16'd0;
    step(3, 0, 0, 0, 16'h0200, 1, "R4 zero threshold releases pin");
    step(3, 0, 1, 16'h0000, 16'h0000, 1, "R6 write clears sticky charge bit");
    step(2, 16'd3, 0, 0, 16'h0000, 1, "R4 zero threshold sets nothing");
    step(3, 0, 1, 16'hFFFF, 16'h9BC0, 1, "R7 R1 write all ones, reserved zero");
    step(3, 0, 1, 16'h0000, 16'h0000, 1, "R7 write zero clears flags");
    thr_volt_lo = 16'd0;
    step(0, 16'd2000, 0, 0, 16'h0000, 1, "R4 voltage low disabled");
    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule